// File: doc/BRIEF.md
# Coarse/Fine Propagation Delay Meter

This block measures how long a timing marker takes to cross a serial link, either one way or round trip. A start pulse, together with the transmit side's word-aligner shift value, marks the moment the marker is sent. A stop pulse, together with the receive side's shift value, marks the moment the marker is detected.

Between the two events, a counter in the system clock domain counts whole clock cycles. Each system clock spans `BITS_PER_CLK` bit periods, which is one code-group. The fine part is the difference between the two shift values. The block reports the coarse count, the signed fine term and their sum in bit periods. It pulses a valid strobe for each completed measurement.

The stop pulse arrives from another clock domain. It passes through a synchroniser of `SYNC_STAGES` flops and an edge detector. The start path is delayed by a matching pipeline, so the synchroniser adds no offset to the count. A measurement that runs past the counter range is dropped, and an overflow flag is raised.

Top module: `prop_delay_meter`

## Requirements
- R1: While reset is asserted (rst_n low) and directly after it, res_valid_o, coarse_o, fine_o, delay_o and overflow_o are all zero.
- R2: If start_i is first sampled high at clock edge S and stop_i is first sampled high at edge S+k (1 <= k <= 2^CNT_W-1), then coarse_o reports k.
- R3: fine_o is stop_shift_i minus start_shift_i as a two's complement value of SHIFT_W+1 bits. start_shift_i is taken at the edge that samples start_i. stop_shift_i must be held from the rise of stop_i until the result appears.
- R4: delay_o equals coarse_o * BITS_PER_CLK + fine_o, as a two's complement value in bit periods.
- R5: If stop_i is first sampled high at edge E, res_valid_o is high for exactly the one cycle after edge E+SYNC_STAGES. In that same cycle the new results appear.
- R6: coarse_o, fine_o and delay_o hold their values in every cycle in which res_valid_o is low.
- R7: A rising stop_i with no measurement running produces no res_valid_o pulse and leaves the outputs unchanged. This covers a stop after reset and a second stop after a completed measurement.
- R8: A start sampled while a measurement is running restarts it. The count then runs from the latest start.
- R9: A start and a stop sampled at the same edge: the start wins, the stop is ignored, and the new measurement keeps running.
- R10: If no stop arrives within 2^CNT_W-1 cycles of the start, the measurement is dropped. overflow_o goes high, no res_valid_o pulse is produced for it, and the outputs keep their previous values. overflow_o clears when the next start takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (counting) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Marker-sent pulse, clk domain |
| start_shift_i | input | SHIFT_W | Transmit-side bit shift at start |
| stop_i | input | 1 | Marker-detected pulse, asynchronous |
| stop_shift_i | input | SHIFT_W | Receive-side bit shift at stop |
| res_valid_o | output | 1 | One-cycle strobe on a completed measurement |
| coarse_o | output | CNT_W | Whole clock cycles from start to stop |
| fine_o | output | SHIFT_W+1 | Signed shift difference (stop minus start) |
| delay_o | output | CNT_W+clog2(BITS_PER_CLK)+1 | Signed total delay in bit periods |
| overflow_o | output | 1 | Last measurement exceeded the counter range |

## Verification
The bench builds the block with CNT_W=5, BITS_PER_CLK=10, SHIFT_W=4 and SYNC_STAGES=2. With a 5-bit counter the saturation boundary is only 31 cycles away. That makes it cheap to sweep every coarse distance from 1 to the maximum and to push one run past the limit. All 100 pairs of start and stop shift values are also swept. This drives the fine term through every value from -9 to +9 and the total through both signs of the fine part. Directed sequences cover restart, a start and a stop at the same edge, and stops that have no start.

// File: rtl/dm_pkg.sv
`timescale 1ns/1ps
package dm_pkg;
   typedef enum logic [0:0] {MS_IDLE = 1'b0, MS_RUN = 1'b1} meter_st_e;

   // width of the signed total: coarse scaled by bits per clock, plus sign
   function automatic int tot_width(input int cnt_w, input int bits);
      return cnt_w + $clog2(bits) + 1;
   endfunction
endpackage

// File: rtl/dm_start_align.sv
`timescale 1ns/1ps
module dm_start_align #(
   parameter int STAGES  = 2,
   parameter int SHIFT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [SHIFT_W-1:0] shift_i,
   output logic               start_evt_o,
   output logic [SHIFT_W-1:0] shift_o
);
   logic               vq [STAGES];
   logic [SHIFT_W-1:0] sq [STAGES];

   // delay line matching the stop synchroniser latency
   for (genvar g = 0; g < STAGES; g++) begin : g_pipe
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vq[g] <= 1'b0;
               sq[g] <= '0;
            end else begin
               vq[g] <= start_i;
               sq[g] <= shift_i;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vq[g] <= 1'b0;
               sq[g] <= '0;
            end else begin
               vq[g] <= vq[g-1];
               sq[g] <= sq[g-1];
            end
         end
      end
   end

   assign start_evt_o = vq[STAGES-1];
   assign shift_o     = sq[STAGES-1];
endmodule

// File: rtl/dm_stop_sync.sv
`timescale 1ns/1ps
module dm_stop_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_i,
   output logic stop_evt_o
);
   // STAGES synchroniser flops plus one history flop for edge detection
   logic [STAGES:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= {q[STAGES-1:0], stop_i};
   end

   assign stop_evt_o = q[STAGES-1] & ~q[STAGES];
endmodule

// File: rtl/dm_coarse_ctr.sv
`timescale 1ns/1ps
module dm_coarse_ctr
   import dm_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_evt_i,
   input  logic             stop_evt_i,
   output logic             done_o,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   meter_st_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= MS_IDLE;
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (start_evt_i) begin
         st_q  <= MS_RUN;
         cnt_q <= CNT_W'(1);
         ovf_q <= 1'b0;
      end else if (st_q == MS_RUN) begin
         if (stop_evt_i) begin
            st_q <= MS_IDLE;
         end else if (cnt_q == CNT_MAX) begin
            st_q  <= MS_IDLE;
            ovf_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign done_o  = (st_q == MS_RUN) && stop_evt_i && !start_evt_i;
   assign count_o = cnt_q;
   assign ovf_o   = ovf_q;
endmodule

// File: rtl/dm_result.sv
`timescale 1ns/1ps
module dm_result #(
   parameter int CNT_W        = 24,
   parameter int SHIFT_W      = 4,
   parameter int BITS_PER_CLK = 10,
   parameter int TOT_W        = 29
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_evt_i,
   input  logic [SHIFT_W-1:0] start_shift_i,
   input  logic               done_i,
   input  logic [CNT_W-1:0]   count_i,
   input  logic [SHIFT_W-1:0] stop_shift_i,
   output logic               valid_o,
   output logic [CNT_W-1:0]   coarse_o,
   output logic [SHIFT_W:0]   fine_o,
   output logic [TOT_W-1:0]   total_o
);
   localparam bit POW2 = (BITS_PER_CLK & (BITS_PER_CLK - 1)) == 0;

   logic [SHIFT_W-1:0]      base_q;
   logic signed [SHIFT_W:0] fine_n;
   logic [TOT_W-1:0]        scaled;
   logic signed [TOT_W-1:0] fine_ext;
   logic [TOT_W-1:0]        total_n;

   // coarse-to-bit-period scaling: shift when possible, else constant multiply
   if (POW2) begin : g_shl
      assign scaled = TOT_W'(count_i) << $clog2(BITS_PER_CLK);
   end else begin : g_mul
      assign scaled = TOT_W'(count_i) * TOT_W'(BITS_PER_CLK);
   end

   always_comb begin
      fine_n   = $signed({1'b0, stop_shift_i}) - $signed({1'b0, base_q});
      fine_ext = TOT_W'(fine_n);
      total_n  = scaled + fine_ext;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         valid_o  <= 1'b0;
         coarse_o <= '0;
         fine_o   <= '0;
         total_o  <= '0;
      end else begin
         if (start_evt_i) base_q <= start_shift_i;
         valid_o <= done_i;
         if (done_i) begin
            coarse_o <= count_i;
            fine_o   <= fine_n;
            total_o  <= total_n;
         end
      end
   end
endmodule

// File: rtl/prop_delay_meter.sv
`timescale 1ns/1ps
module prop_delay_meter #(
   parameter int CNT_W        = 24,
   parameter int BITS_PER_CLK = 10,
   parameter int SHIFT_W      = 4,
   parameter int SYNC_STAGES  = 2,
   localparam int TOT_W       = dm_pkg::tot_width(CNT_W, BITS_PER_CLK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [SHIFT_W-1:0] start_shift_i,
   input  logic               stop_i,
   input  logic [SHIFT_W-1:0] stop_shift_i,
   output logic               res_valid_o,
   output logic [CNT_W-1:0]   coarse_o,
   output logic [SHIFT_W:0]   fine_o,
   output logic [TOT_W-1:0]   delay_o,
   output logic               overflow_o
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (BITS_PER_CLK < 2) begin : g_bad_bits
      $error("BITS_PER_CLK must be at least 2");
   end
   if (SHIFT_W < $clog2(BITS_PER_CLK)) begin : g_bad_shift
      $error("SHIFT_W too narrow for BITS_PER_CLK");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic               start_evt;
   logic [SHIFT_W-1:0] start_shift_d;
   logic               stop_evt;
   logic               done;
   logic [CNT_W-1:0]   count;

   dm_start_align #(.STAGES(SYNC_STAGES), .SHIFT_W(SHIFT_W)) u_align (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .shift_i(start_shift_i),
      .start_evt_o(start_evt), .shift_o(start_shift_d)
   );

   dm_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .stop_evt_o(stop_evt)
   );

   dm_coarse_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .start_evt_i(start_evt), .stop_evt_i(stop_evt),
      .done_o(done), .count_o(count), .ovf_o(overflow_o)
   );

   dm_result #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .BITS_PER_CLK(BITS_PER_CLK),
               .TOT_W(TOT_W)) u_res (
      .clk(clk), .rst_n(rst_n), .start_evt_i(start_evt), .start_shift_i(start_shift_d),
      .done_i(done), .count_i(count), .stop_shift_i(stop_shift_i),
      .valid_o(res_valid_o), .coarse_o(coarse_o), .fine_o(fine_o), .total_o(delay_o)
   );
endmodule

// File: rtl/dm_checker.sv
`timescale 1ns/1ps
module dm_checker #(
   parameter int CNT_W        = 24,
   parameter int BITS_PER_CLK = 10,
   parameter int SHIFT_W      = 4,
   parameter int TOT_W        = 29
) (
   input logic               clk,
   input logic               rst_n,
   input logic               valid,
   input logic [CNT_W-1:0]   coarse,
   input logic [SHIFT_W:0]   fine,
   input logic [TOT_W-1:0]   total,
   input logic               ovf
);
   p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> ($stable(coarse) && $stable(fine) && $stable(total)));

   p_coarse_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (coarse != '0));

   p_fine_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (($signed(fine) > -BITS_PER_CLK) && ($signed(fine) < BITS_PER_CLK)));

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> !valid);
endmodule

bind prop_delay_meter dm_checker #(
   .CNT_W(CNT_W), .BITS_PER_CLK(BITS_PER_CLK), .SHIFT_W(SHIFT_W), .TOT_W(TOT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .valid(res_valid_o), .coarse(coarse_o),
   .fine(fine_o), .total(delay_o), .ovf(overflow_o)
);

// File: tb/sim_prop_delay_meter.sv
`timescale 1ns/1ps
module sim_prop_delay_meter;
   localparam int CW   = 5;
   localparam int BITS = 10;
   localparam int SW   = 4;
   localparam int SYNC = 2;
   localparam int MAXC = (1 << CW) - 1;
   localparam int TW   = CW + $clog2(BITS) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [SW-1:0] start_shift_i = '0;
   logic          stop_i = 1'b0;
   logic [SW-1:0] stop_shift_i = '0;
   logic          res_valid_o;
   logic [CW-1:0] coarse_o;
   logic [SW:0]   fine_o;
   logic [TW-1:0] delay_o;
   logic          overflow_o;

   int  n_cmp = 0;
   int  n_bad = 0;
   int  vcount = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   prop_delay_meter #(.CNT_W(CW), .BITS_PER_CLK(BITS), .SHIFT_W(SW), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_shift_i(start_shift_i),
      .stop_i(stop_i), .stop_shift_i(stop_shift_i), .res_valid_o(res_valid_o),
      .coarse_o(coarse_o), .fine_o(fine_o), .delay_o(delay_o), .overflow_o(overflow_o)
   );

   always @(negedge clk) if (rst_n && res_valid_o) vcount++;

   task automatic chk(input string req, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // start sampled at edge S, stop sampled at edge S+k
   task automatic measure(input int k, input int ss, input int es);
      @(negedge clk);
      start_i = 1'b1;
      start_shift_i = ss[SW-1:0];
      @(posedge clk);
      for (int j = 1; j <= k; j++) begin
         @(negedge clk);
         if (j == 1) start_i = 1'b0;
         if (j == k) begin
            stop_i = 1'b1;
            stop_shift_i = es[SW-1:0];
         end
      end
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk("R5 no early valid", res_valid_o, 0);
      @(posedge clk);
      @(negedge clk);
      chk("R5 valid strobe", res_valid_o, 1);
      chk("R2 coarse", coarse_o, k);
      chk("R3 fine", $signed(fine_o), es - ss);
      chk("R4 delay", $signed(delay_o), k * BITS + es - ss);
      stop_i = 1'b0;
      @(negedge clk);
      chk("R5 one cycle", res_valid_o, 0);
      chk("R6 hold", coarse_o, k);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int v0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 valid", res_valid_o, 0);
      chk("R1 coarse", coarse_o, 0);
      chk("R1 fine", fine_o, 0);
      chk("R1 delay", delay_o, 0);
      chk("R1 overflow", overflow_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", coarse_o, 0);

      // R7: stop with no start
      v0 = vcount;
      stop_i = 1'b1; stop_shift_i = 4'd5;
      repeat (3) @(negedge clk);
      stop_i = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7 stray stop valid count", vcount - v0, 0);
      chk("R7 stray stop coarse", coarse_o, 0);

      // R3/R4: every shift pair
      for (int a = 0; a < BITS; a++)
         for (int b = 0; b < BITS; b++)
            measure(((a * 3 + b) % MAXC) + 1, a, b);

      // R2: every coarse distance up to the counter limit
      for (int k = 1; k <= MAXC; k++)
         measure(k, k % BITS, (k * 7) % BITS);

      // R7: second stop after a completed measurement
      v0 = vcount;
      stop_i = 1'b1; stop_shift_i = 4'd1;
      repeat (3) @(negedge clk);
      stop_i = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7 second stop valid count", vcount - v0, 0);
      chk("R7 second stop coarse kept", coarse_o, MAXC);

      // R8: restart while running
      @(negedge clk); start_i = 1'b1; start_shift_i = 4'd2;
      @(negedge clk); start_i = 1'b0;
      repeat (4) @(negedge clk);
      v0 = vcount;
      measure(7, 3, 8);
      chk("R8 single result after restart", vcount - v0, 1);

      // R9: start and stop sampled at the same edge
      @(negedge clk); start_i = 1'b1; start_shift_i = 4'd0;
      @(negedge clk); start_i = 1'b0;
      repeat (3) @(negedge clk);
      v0 = vcount;
      start_i = 1'b1; start_shift_i = 4'd4;
      stop_i = 1'b1;  stop_shift_i = 4'd9;
      @(posedge clk);
      for (int j = 1; j <= 8; j++) begin
         @(negedge clk);
         if (j == 1) start_i = 1'b0;
         if (j == 3) stop_i = 1'b0;
         if (j == 8) begin stop_i = 1'b1; stop_shift_i = 4'd1; end
      end
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk("R9 simultaneous stop ignored", vcount - v0, 0);
      @(posedge clk);
      @(negedge clk);
      chk("R9 valid from later stop", res_valid_o, 1);
      chk("R9 coarse from restart", coarse_o, 8);
      chk("R9 fine from restart", $signed(fine_o), 1 - 4);
      stop_i = 1'b0;
      repeat (4) @(negedge clk);

      // R10: overflow past the counter limit
      v0 = vcount;
      @(negedge clk); start_i = 1'b1; start_shift_i = 4'd6;
      @(negedge clk); start_i = 1'b0;
      repeat (MAXC + 6) @(negedge clk);
      chk("R10 overflow flag", overflow_o, 1);
      stop_i = 1'b1; stop_shift_i = 4'd2;
      repeat (3) @(negedge clk);
      stop_i = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10 no result on overflow", vcount - v0, 0);
      chk("R10 coarse kept", coarse_o, 8);
      chk("R10 flag held", overflow_o, 1);
      measure(4, 9, 0);
      chk("R10 flag cleared by start", overflow_o, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule